// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Overflow Interrupts

The block is a 16-bit up-counter driven by one of two selectable tick sources: a machine-cycle enable (one pulse per oscillator-divided-by-twelve cycle) or rising edges on an external count pin. A power-of-two prescaler sits between the source and the counter. An enabled rising edge on an external reset pin clears the counter.

Two sticky flags record overflow events. One is set when the low byte rolls over and the other when the full count wraps. Each flag can raise a shared interrupt request under its own select bit. Software programs an 8-bit control register and services the flags through a one-address-bit register port. A flag is cleared by writing 0 to its bit.

Top module: `presc_timer16`

## Requirements
- R1: While rst_ni is low, count_o, the control register, both flags and irq_o are 0.
- R2: Control bits [1:0] pick the source. Code 00 (off) and code 10 (test, treated as off) hold count_o unchanged.
- R3: With code 01, each clock cycle with mc_en_i high is one source tick. count_o advances one clock after the tick is seen, subject to R5.
- R4: With code 11, each rising edge of cnt_pin_i is one source tick. The pin passes through a two-flop synchroniser, so the count changes on the third rising clock edge after the pin rises. Levels and falling edges do nothing.
- R5: Control bits [3:2] = 00, 01, 10, 11 divide source ticks by 1, 2, 4, 8. After reset or an external clear, the first count step comes on the 2^n-th source tick.
- R6: When control bit 5 is 1, a synchronised rising edge of rst_pin_i clears count_o and the prescaler three clock edges after the pin rises. This happens in every mode and takes priority over counting. When bit 5 is 0, the pin has no effect.
- R7: The byte-overflow flag (control bit 4, byte_ovf_o) is set when a count step takes the low byte from FF to 00. This includes the full 16-bit wrap. An external clear does not set it.
- R8: The word-overflow flag (word_ovf_o, read at address 1 bit 0) is set when a count step takes count_o from FFFF to 0000.
- R9: Writing 0 to a flag bit clears that flag and writing 1 leaves it unchanged. If a set event arrives in the same cycle as a clearing write, the flag stays set.
- R10: irq_o equals (byte flag AND control bit 6) OR (word flag AND control bit 7).
- R11: reg_rdata_o returns the control register with the byte flag at bit 4 when reg_sel_i is 0. When reg_sel_i is 1, it returns zeros with the word flag at bit 0. Writes to address 0 load bits 7:5 and 3:0 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | Machine-cycle enable pulse |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| rst_pin_i | input | 1 | External reset pin, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register address: 0 control, 1 word flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| count_o | output | 16 | Current count |
| byte_ovf_o | output | 1 | Byte-overflow flag |
| word_ovf_o | output | 1 | Word-overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The machine-cycle source is driven with a sparse enable pattern and with a constant enable. This separates counting per enable pulse from counting per clock, and it exposes each prescaler ratio. The count pin is toggled at two rates, including the fastest one, so that edge detection can be told apart from level sensing and the synchroniser latency is pinned down. External reset pulses are sent with the enable bit off and on. Byte and word wraps are run to completion with clearing writes placed on the exact wrap cycle, which separates set-over-clear priority from a plain clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PRE_W = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_MC   = 2'b01,
    MODE_TEST = 2'b10,
    MODE_PIN  = 2'b11
  } tmr_mode_e;

  // bit order is the register layout
  typedef struct packed {
    logic             word_ie;
    logic             byte_ie;
    logic             xrst_en;
    logic             byte_flag;
    logic [PRE_W-1:0] presc;
    tmr_mode_e        mode;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_tick_i,
  input  logic [PRE_W-1:0] div_sel_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;

  assign mask   = ~({DIV_W{1'b1}} << div_sel_i);
  assign tick_o = src_tick_i & (&(pre_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (clr_i)      pre_q <= '0;
    else if (src_tick_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             low_wrap_o,
  output logic             full_wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o     = cnt_q;
  assign low_wrap_o  = tick_i & ~clr_i & (&cnt_q[LOW_W-1:0]);
  assign full_wrap_o = tick_i & ~clr_i & (&cnt_q);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic      sel_i,
  input  logic [7:0] wdata_i,
  input  logic      byte_set_i,
  input  logic      word_set_i,
  output tmr_ctrl_t ctrl_o,
  output logic      word_flag_o,
  output logic [7:0] rdata_o
);
  tmr_ctrl_t ctrl_q, ctrl_d;
  logic      word_q, word_d;

  always_comb begin
    ctrl_d = ctrl_q;
    word_d = word_q;
    if (we_i && !sel_i) begin
      ctrl_d           = tmr_ctrl_t'(wdata_i);
      ctrl_d.byte_flag = ctrl_q.byte_flag & wdata_i[4];
    end
    if (we_i && sel_i) word_d = word_q & wdata_i[0];
    // set beats clear
    ctrl_d.byte_flag = ctrl_d.byte_flag | byte_set_i;
    word_d           = word_d | word_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      word_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      word_q <= word_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign word_flag_o = word_q;
  assign rdata_o     = sel_i ? {7'b0, word_q} : ctrl_q;
endmodule

// File: rtl/presc_timer16.sv
module presc_timer16
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LOW_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mc_en_i,
  input  logic             cnt_pin_i,
  input  logic             rst_pin_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             byte_ovf_o,
  output logic             word_ovf_o,
  output logic             irq_o
);
  localparam int N_PINS = 2;

  tmr_ctrl_t   ctrl;
  tmr_mode_e   mode;
  logic [N_PINS-1:0] pins, rises;
  logic cnt_rise, rst_rise, src_tick, cnt_tick, ext_clr;
  logic low_wrap, full_wrap, word_flag;

  assign pins = {rst_pin_i, cnt_pin_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[g]),
      .rise_o(rises[g])
    );
  end

  assign cnt_rise = rises[0];
  assign rst_rise = rises[1];
  assign mode     = ctrl.mode;
  assign src_tick = ((mode == MODE_MC) & mc_en_i) | ((mode == MODE_PIN) & cnt_rise);
  assign ext_clr  = ctrl.xrst_en & rst_rise;

  tmr_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_tick_i(src_tick),
    .div_sel_i (ctrl.presc),
    .clr_i     (ext_clr),
    .tick_o    (cnt_tick)
  );

  tmr_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (cnt_tick),
    .clr_i      (ext_clr),
    .count_o    (count_o),
    .low_wrap_o (low_wrap),
    .full_wrap_o(full_wrap)
  );

  tmr_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .byte_set_i (low_wrap),
    .word_set_i (full_wrap),
    .ctrl_o     (ctrl),
    .word_flag_o(word_flag),
    .rdata_o    (reg_rdata_o)
  );

  assign byte_ovf_o = ctrl.byte_flag;
  assign word_ovf_o = word_flag;
  assign irq_o      = (ctrl.byte_flag & ctrl.byte_ie) | (word_flag & ctrl.word_ie);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16,
  parameter int LOW_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic             byte_ovf_o,
  input logic             word_ovf_o,
  input logic             irq_o,
  input logic             reg_we_i,
  input logic             reg_sel_i,
  input logic [1:0]       mode,
  input logic             ext_clr
);
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == 2'b00 || mode == 2'b10) && !ext_clr) |=> $stable(count_o)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_o == $past(count_o) + 1'b1 || count_o == '0 || $stable(count_o))); // R3

  AST_XRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_clr |=> (count_o == '0)); // R6

  AST_BYTE_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ext_clr) && count_o == $past(count_o) + 1'b1 && count_o[LOW_W-1:0] == '0) |-> byte_ovf_o); // R7

  AST_WORD_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_ovf_o && !(reg_we_i && reg_sel_i)) |=> word_ovf_o); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_ovf_o && !word_ovf_o) |-> !irq_o); // R10
endmodule

bind presc_timer16 tmr_checker #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_o   (count_o),
  .byte_ovf_o(byte_ovf_o),
  .word_ovf_o(word_ovf_o),
  .irq_o     (irq_o),
  .reg_we_i  (reg_we_i),
  .reg_sel_i (reg_sel_i),
  .mode      (mode),
  .ext_clr   (ext_clr)
);

// File: tb/test_presc_timer16.sv
`timescale 1ns/1ps
module test_presc_timer16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mc_en = 0, cnt_pin = 0, rst_pin = 0, we = 0, sel = 0;
  logic [7:0] wdata = 0, rdata;
  logic [15:0] count;
  logic byte_ovf, word_ovf, irq;

  presc_timer16 i_presc_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .mc_en_i(mc_en), .cnt_pin_i(cnt_pin),
    .rst_pin_i(rst_pin), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .count_o(count), .byte_ovf_o(byte_ovf),
    .word_ovf_o(word_ovf), .irq_o(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_cnt = 0, m_pcnt = 0, m_ctrl = 0, m_bf = 0, m_wf = 0;
  int ph[3] = '{0, 0, 0};
  int rh[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pcnt = 0; m_ctrl = 0; m_bf = 0; m_wf = 0;
      ph = '{0, 0, 0}; rh = '{0, 0, 0};
    end else begin
      int md, dv, ce, re, src, tck, bs, ws;
      md = m_ctrl & 3;
      dv = 1 << ((m_ctrl >> 2) & 3);
      ce = ph[1] & ~ph[2] & 1;
      re = rh[1] & ~rh[2] & 1;
      ph[2] = ph[1]; ph[1] = ph[0]; ph[0] = int'(cnt_pin);
      rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = int'(rst_pin);
      src = ((md == 1) && mc_en) || ((md == 3) && ce == 1);
      tck = 0; bs = 0; ws = 0;
      if (((m_ctrl >> 5) & 1) == 1 && re == 1) begin
        m_cnt = 0; m_pcnt = 0;
      end else if (src) begin
        if ((m_pcnt % dv) == dv - 1) tck = 1;
        m_pcnt = (m_pcnt + 1) % 8;
      end
      if (tck) begin
        bs = ((m_cnt % 256) == 255);
        ws = (m_cnt == 65535);
        m_cnt = (m_cnt + 1) % 65536;
      end
      if (we && !sel) begin
        m_ctrl = int'(wdata) & 8'hEF;
        m_bf = m_bf & int'(wdata[4]);
      end
      if (we && sel) m_wf = m_wf & int'(wdata[0]);
      m_bf = m_bf | bs;
      m_wf = m_wf | ws;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    if (rst_n) begin
      int exp_irq, exp_rd;
      exp_irq = (m_bf & (m_ctrl >> 6) & 1) | (m_wf & (m_ctrl >> 7) & 1);
      exp_rd  = sel ? m_wf : (m_ctrl | (m_bf << 4));
      chk(int'(count) == m_cnt, cur_req, int'(count), m_cnt);
      chk(int'(byte_ovf) == m_bf, "R7", int'(byte_ovf), m_bf);
      chk(int'(word_ovf) == m_wf, "R8", int'(word_ovf), m_wf);
      chk(int'(irq) == exp_irq, "R10", int'(irq), exp_irq);
      chk(int'(rdata) == exp_rd, "R11", int'(rdata), exp_rd);
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic s, input logic [7:0] d);
    we = 1; sel = s; wdata = d;
    @(negedge clk);
    we = 0; sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(count == 16'h0, "R1", int'(count), 0);
    chk({byte_ovf, word_ovf, irq} == 3'b0, "R1", int'({byte_ovf, word_ovf, irq}), 0);
    chk(rdata == 8'h00, "R1", int'(rdata), 0);
    rst_n = 1;
    @(negedge clk);

    // R2: off and test codes hold
    cur_req = "R2"; mc_en = 1;
    wr(0, 8'h00); idle(10);
    wr(0, 8'h02); idle(10);
    wr(0, 8'h0E); idle(10);

    // R3: sparse machine-cycle enable, divide by 1
    cur_req = "R3";
    wr(0, 8'h01);
    for (int i = 0; i < 40; i++) begin mc_en = (i % 3 == 0); @(negedge clk); end

    // R5: each prescaler ratio, constant and sparse enable
    cur_req = "R5";
    for (int p = 1; p < 4; p++) begin
      wr(0, 8'(p << 2) | 8'h01);
      for (int i = 0; i < 40; i++) begin mc_en = (i < 20) ? 1'b1 : (i % 2 == 0); @(negedge clk); end
    end
    mc_en = 0;

    // R4: pin source, slow and fastest toggling, also with prescaler
    cur_req = "R4";
    wr(0, 8'h03);
    for (int i = 0; i < 40; i++) begin cnt_pin = (i % 4) < 2; @(negedge clk); end
    for (int i = 0; i < 20; i++) begin cnt_pin = ~cnt_pin; @(negedge clk); end
    cnt_pin = 1; idle(10);
    wr(0, 8'h07);
    for (int i = 0; i < 30; i++) begin cnt_pin = ~cnt_pin; @(negedge clk); end
    cnt_pin = 0; idle(5);

    // R6: external reset, disabled then enabled
    cur_req = "R6";
    wr(0, 8'h01); mc_en = 1; idle(10);
    rst_pin = 1; idle(3); rst_pin = 0; idle(5);
    wr(0, 8'h21); idle(6);
    rst_pin = 1; idle(3); rst_pin = 0; idle(5);
    wr(0, 8'h29); idle(5);
    rst_pin = 1; idle(8); rst_pin = 0; idle(5);
    wr(0, 8'h23); mc_en = 0;
    cnt_pin = 1; idle(4); cnt_pin = 0; rst_pin = 1; idle(4); rst_pin = 0; idle(4);

    // R7/R9/R10: byte wrap, clear, write-1, collision
    cur_req = "R7";
    wr(0, 8'h41); mc_en = 1;
    while (!byte_ovf) @(negedge clk);
    idle(3);
    cur_req = "R9";
    wr(0, 8'h51); idle(2);
    wr(0, 8'h41); idle(2);
    while (count[7:0] != 8'hFF) @(negedge clk);
    wr(0, 8'h41); idle(3);
    wr(0, 8'h01); idle(2);

    // R8/R9/R10: full wrap with clearing write on the wrap cycle
    cur_req = "R8";
    wr(0, 8'h81);
    while (count != 16'hFFFF) @(negedge clk);
    wr(1, 8'h00); idle(3);
    wr(1, 8'h01); idle(2);
    wr(1, 8'h00); idle(2);
    wr(1, 8'h01); idle(2);
    sel = 1; idle(2); sel = 0; idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule